// File: doc/BRIEF.md
# Dual-Comparator Timer with PWM

This block is a 16-bit up-counting timer. A clock-enable tick advances the counter while a run bit is set. Two compare values watch the counter. Compare A is a full 16-bit value. Compare P is an 8-bit value that is checked against the counter's upper byte only, so it sets periods in steps of 256 ticks. A P value of zero selects the full 65536-tick range.

In timer mode, a clear-select bit chooses which compare match returns the counter to zero. The counter also wraps to zero from its maximum value.

In PWM mode the counter restarts on a period match. The output is high from count 0 until the count reaches the duty threshold, and low for the rest of the period. A role-swap bit chooses which compare value sets the period and which sets the duty. A polarity bit inverts the PWM pin. Each match event and the overflow event produce a one-clock flag pulse.

Top module: `dual_cmp_timer`

## Requirements
- R1: For a nonzero P value N, match_p pulses one clock after the tick on which the counter steps from N*256-1 to N*256. In timer mode with clr_sel_a=0, that tick clears the counter, so the period is N*256 ticks.
- R2: With a P value of 0, match_p and ovf both pulse one clock after the tick taken at count 16'hFFFF. The P period is then 65536 ticks.
- R3: In timer mode with clr_sel_a=1, a tick at count A-1 raises match_a and clears the counter. The period is A ticks, and a value of A=0 gives 65536 ticks.
- R4: In timer mode with clr_sel_a=0, the counter is cleared by a P match or by wrapping from 16'hFFFF. Any tick at 16'hFFFF pulses ovf.
- R5: In PWM mode clr_sel_a has no effect on the counter or on the output.
- R6: In PWM mode with duplex=0, P sets the period and A sets the duty threshold. With duplex=1, A sets the period (0 means 65536) and the duty threshold is P*256 (P=0 means 65536).
- R7: The un-inverted PWM level is 1 while count < duty. With invert=1 the pin is the complement of that level. In timer mode the pin is 0 whatever the value of invert.
- R8: After reset the counter is 0 and all outputs are 0.
- R9: The flags are registered and pulse for one clock only on ticks taken while run=1. When tick or run is 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable strobe |
| run | input | 1 | Counter run control |
| mode_pwm | input | 1 | 1 = PWM mode, 0 = timer mode |
| clr_sel_a | input | 1 | Timer mode clear source: 1 = A match, 0 = P match or wrap |
| duplex | input | 1 | PWM role swap: 0 = P period / A duty, 1 = A period / P duty |
| invert | input | 1 | PWM output polarity inversion |
| cmp_a | input | 16 | Full-width compare value A |
| cmp_p | input | 8 | Compare value P, checked against the counter upper byte |
| pwm_out | output | 1 | PWM pin |
| match_a | output | 1 | A match pulse |
| match_p | output | 1 | P match pulse |
| ovf | output | 1 | Counter overflow pulse |

## Verification
The assertions check several rules on every cycle:
- a flag rises only after a tick taken while running;
- an overflow follows the maximum count;
- a zero P value pairs its match with the overflow;
- the counter reads zero after a selected timer-mode clear;
- the counter is frozen when not stepping;
- the pin stays low in timer mode.

Only the bench scenarios can show whole-waveform properties: the exact period lengths, the duty thresholds under both role assignments, the 65536-tick range, and the fact that clr_sel_a changes nothing in PWM mode. The bench shows these by comparing each cycle against a model computed from the requirements.

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          mode_pwm,
  input  logic          clr_sel_a,
  input  logic          duplex,
  input  logic          invert,
  input  logic [CW-1:0] cmp_a,
  input  logic [PW-1:0] cmp_p,
  output logic          pwm_out,
  output logic          match_a,
  output logic          match_p,
  output logic          ovf
);
  localparam int LW = CW - PW;

  logic [CW-1:0] cnt;
  logic [CW-1:0] inc;
  logic [CW-1:0] p_full;
  logic [CW:0]   duty_t;
  logic          at_max, hit_a, hit_p, per_hit, clr, step, pwm_raw;

  assign step    = tick & run;
  assign inc     = cnt + 1'b1;
  assign at_max  = &cnt;
  assign p_full  = {cmp_p, {LW{1'b0}}};
  assign hit_a   = (inc == cmp_a);
  assign hit_p   = (cmp_p == '0) ? at_max : (inc == p_full);
  assign per_hit = duplex ? hit_a : hit_p;
  assign clr     = mode_pwm ? per_hit : (clr_sel_a ? hit_a : hit_p);

  always_comb begin
    if (!duplex)
      duty_t = {1'b0, cmp_a};
    else if (cmp_p == '0)
      duty_t = {1'b1, {CW{1'b0}}};
    else
      duty_t = {1'b0, p_full};
  end

  assign pwm_raw = ({1'b0, cnt} < duty_t);
  assign pwm_out = mode_pwm & (pwm_raw ^ invert);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      match_a <= 1'b0;
      match_p <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      match_a <= step & hit_a;
      match_p <= step & hit_p;
      ovf     <= step & at_max;
      if (step)
        cnt <= clr ? '0 : inc;
    end
  end
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          run,
  input logic          mode_pwm,
  input logic          clr_sel_a,
  input logic [PW-1:0] cmp_p,
  input logic [CW-1:0] cnt,
  input logic          pwm_out,
  input logic          match_a,
  input logic          match_p,
  input logic          ovf
);
  p_flag_a_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |-> $past(tick && run));
  p_flag_p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_p |-> $past(tick && run));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && run) |=> $stable(cnt));
  p_ovf_from_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> ($past(cnt) == {CW{1'b1}}));
  p_zero_p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && ($past(cmp_p) == '0)) |-> match_p);
  p_clear_on_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && $past(!mode_pwm && clr_sel_a)) |-> (cnt == '0));
  p_clear_on_p_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (match_p && $past(!mode_pwm && !clr_sel_a)) |-> (cnt == '0));
  p_timer_pin_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_pwm |-> !pwm_out);
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.CW(CW), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .mode_pwm(mode_pwm),
  .clr_sel_a(clr_sel_a), .cmp_p(cmp_p), .cnt(cnt), .pwm_out(pwm_out),
  .match_a(match_a), .match_p(match_p), .ovf(ovf)
);

// File: tb/dual_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, mode_pwm = 1'b0, clr_sel_a = 1'b0;
  logic duplex = 1'b0, invert = 1'b0;
  logic [15:0] cmp_a = '0;
  logic [7:0]  cmp_p = '0;
  logic pwm_out, match_a, match_p, ovf;

  int n_chk = 0, n_bad = 0, mcnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .mode_pwm(mode_pwm),
    .clr_sel_a(clr_sel_a), .duplex(duplex), .invert(invert),
    .cmp_a(cmp_a), .cmp_p(cmp_p), .pwm_out(pwm_out),
    .match_a(match_a), .match_p(match_p), .ovf(ovf)
  );

  function automatic int per_a(input logic [15:0] a);
    return (a == 0) ? 65536 : int'(a);
  endfunction
  function automatic int per_p(input logic [7:0] p);
    return (p == 0) ? 65536 : int'(p) * 256;
  endfunction
  function automatic logic exp_pin(input int c);
    int duty;
    duty = duplex ? per_p(cmp_p) : int'(cmp_a);
    if (!mode_pwm) return 1'b0;
    return (c < duty) ^ invert;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic cyc(input string tag);
    logic ea, ep, eo, stp, clr;
    int nxt;
    stp = tick && run;
    ea  = stp && (mcnt + 1 == per_a(cmp_a));
    ep  = stp && (mcnt + 1 == per_p(cmp_p));
    eo  = stp && (mcnt == 65535);
    if (mode_pwm) clr = duplex ? ea : ep;
    else          clr = clr_sel_a ? ea : ep;
    nxt = stp ? (clr ? 0 : (mcnt + 1) % 65536) : mcnt;
    @(posedge clk);
    @(negedge clk);
    mcnt = nxt;
    n_chk++;
    if (match_a !== ea || match_p !== ep || ovf !== eo || pwm_out !== exp_pin(mcnt)) begin
      n_bad++;
      $display("FAIL %s: a/p/o/pin actual %b%b%b%b expected %b%b%b%b", tag,
               match_a, match_p, ovf, pwm_out, ea, ep, eo, exp_pin(mcnt));
    end
  endtask

  task automatic run_for(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic restart();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mcnt = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d5a));
    repeat (3) @(negedge clk);
    n_chk++;
    if ({pwm_out, match_a, match_p, ovf} !== 4'b0) begin
      n_bad++;
      $display("FAIL R8: outputs actual %b expected 0000", {pwm_out, match_a, match_p, ovf});
    end
    rst_n = 1'b1;
    cyc("R8 idle after reset");

    tick = 1; run = 1; clr_sel_a = 1; cmp_a = 16'd10; cmp_p = 8'd3;
    run_for(40, "R3 timer clear on A");
    cmp_a = 16'd1;
    run_for(6, "R3 A=1 every tick");

    restart();
    clr_sel_a = 0; cmp_p = 8'd1; cmp_a = 16'd100;
    run_for(600, "R1 timer P=1 period 256");
    cmp_p = 8'd2;
    run_for(1100, "R1 timer P=2 period 512");

    restart();
    cmp_p = 8'd0; cmp_a = 16'd5;
    run_for(65540, "R2 R4 P=0 full wrap");

    restart();
    invert = 1; run_for(20, "R7 invert ignored in timer mode");
    mode_pwm = 1; invert = 0; duplex = 0; cmp_p = 8'd1; cmp_a = 16'd64;
    run_for(600, "R6 duplex0 period P duty A");
    invert = 1; run_for(300, "R7 inverted PWM");
    clr_sel_a = 1; run_for(600, "R5 clr_sel ignored in PWM");
    invert = 0; duplex = 1; cmp_a = 16'd600; cmp_p = 8'd2;
    run_for(1300, "R6 duplex1 period A duty P");
    cmp_p = 8'd0; cmp_a = 16'd50;
    run_for(120, "R6 duplex1 P=0 duty full");
    cmp_a = 16'd0; cmp_p = 8'd1; duplex = 0;
    run_for(300, "R6 duty 0 always low");

    run = 0; run_for(30, "R9 run low holds");
    run = 1; tick = 0; run_for(30, "R9 tick low holds");

    restart();
    for (int k = 0; k < 400; k++) begin
      mode_pwm  = $urandom_range(0, 1);
      clr_sel_a = $urandom_range(0, 1);
      duplex    = $urandom_range(0, 1);
      invert    = $urandom_range(0, 1);
      cmp_a     = 16'($urandom_range(1, 700));
      cmp_p     = 8'($urandom_range(1, 3));
      for (int j = 0; j < 60; j++) begin
        tick = ($urandom_range(0, 3) != 0);
        run  = ($urandom_range(0, 7) != 0);
        cyc("R9 R6 R3 R1 random mix");
      end
    end
    finish_run();
  end
endmodule